// File: doc/BRIEF.md
# Scanline Forward-Difference Pixel Array

This block renders one scanline in a linear array of per-pixel cells. A stream of span instructions arrives over a valid/ready handshake. Each instruction names a start pixel, a span length and up to three 36-bit operands: a base intensity, a slope and a curvature. Every cell inside the span works out its own interpolated value from its offset within the span. It then adds that value into a private 36-bit accumulator, so constant, linear and quadratic spans can overlap on the same pixel and sum there.

Two commands change how later spans act. A direct-set span writes a pixel's accumulator outright and locks that pixel until the next refresh. A mask command blanks a range of pixels for the next eval only. A per-instruction clip flag drops negative interpolated values instead of adding them. A refresh command shifts out the upper 12 bits of each accumulator in pixel order, one pixel per cycle, and clears all cell state. No new instruction is accepted until the shift-out is complete.

Top module: `dfa_scanline`

## Requirements
- R1: After reset, instr_ready_o is high, pix_valid_o is low, and every accumulator, lock and mask is zero. A refresh right after reset emits only zero pixels.
- R2: Op 2 (constant) adds i to the accumulator of every pixel p with x <= p < x+dx. Pixels outside that range, including any at or beyond NUM_PIX, are unchanged.
- R3: Op 3 (linear) adds i + k*di at pixel p, where k = p - x. All arithmetic wraps modulo 2^36.
- R4: Op 4 (quadratic) adds the value that sequential forward differencing gives: the value starts at i, the slope starts at di, and after each pixel the value grows by the slope and the slope grows by ddi. Wraparound is modulo 2^36.
- R5: Spans from any number of eval ops that cover the same pixel sum into its accumulator.
- R6: Op 1 (direct set) writes i into each accumulator in the span, with the clip flag having no effect. Each such pixel is then locked, and later eval ops leave it unchanged until a refresh.
- R7: Op 5 (mask) marks the pixels in [x, x+dx). The next eval op (ops 1 to 4) leaves marked pixels unchanged and then clears every mark.
- R8: When instr_clip_i is high on ops 2 to 4, a pixel whose interpolated value has bit 35 set adds nothing. When instr_clip_i is low, that value wraps into the accumulator.
- R9: Op 6 (refresh), accepted at edge E, drives pix_valid_o high for exactly NUM_PIX cycles after E, with pix_o equal to accumulator bits 35:24 of pixel 0, 1, and so on in turn. instr_ready_o is low throughout. All accumulators, locks and masks are cleared at E.
- R10: A span with dx = 0, or with x at or beyond NUM_PIX, changes no state. Op 0 (no-op) also changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction present |
| instr_ready_o | output | 1 | Instruction accepted this cycle when valid is also high |
| instr_op_i | input | 3 | Opcode: 0 nop, 1 set, 2 constant, 3 linear, 4 quadratic, 5 mask, 6 refresh |
| instr_clip_i | input | 1 | Drop negative interpolated values |
| instr_x_i | input | COORD_W | Start pixel |
| instr_dx_i | input | COORD_W | Span length in pixels |
| instr_i_i | input | DATA_W | Base intensity |
| instr_di_i | input | DATA_W | First difference |
| instr_ddi_i | input | DATA_W | Second difference |
| pix_valid_o | output | 1 | Refresh pixel present |
| pix_o | output | PIX_W | Upper accumulator bits of the current pixel |

## Verification
Accumulator state can only be seen at the ports through a refresh. A wrong sum, a lock or mask that fails to hold or fails to clear, or an off-by-one span edge shows up as a wrong pixel value in the next shift-out, at that pixel's position in the sequence. The bench therefore refreshes after every short batch of instructions, so each fault shows up within a few instructions. Handshake faults show up at once: ready rising during a shift, or a shift-out of the wrong length, both change when the next instruction is accepted.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_SET     = 3'd1,
    OP_CONST   = 3'd2,
    OP_LIN     = 3'd3,
    OP_QUAD    = 3'd4,
    OP_MASK    = 3'd5,
    OP_REFRESH = 3'd6
  } dfa_op_e;
endpackage

// File: rtl/dfa_interp.sv
module dfa_interp
  import dfa_pkg::*;
#(
  parameter int unsigned DATA_W  = 36,
  parameter int unsigned COORD_W = 8
) (
  input  logic [COORD_W-1:0] k_i,
  input  dfa_op_e            op_i,
  input  logic [DATA_W-1:0]  i_i,
  input  logic [DATA_W-1:0]  di_i,
  input  logic [DATA_W-1:0]  ddi_i,
  output logic [DATA_W-1:0]  val_o
);
  localparam int unsigned KK_W = 2 * COORD_W;

  logic [KK_W-1:0]   k_ext;
  logic [KK_W-1:0]   kk;
  logic [DATA_W-1:0] k_w;
  logic [DATA_W-1:0] tri_w;
  logic [DATA_W-1:0] lin_term;
  logic [DATA_W-1:0] quad_term;

  assign k_ext     = KK_W'(k_i);
  assign kk        = k_ext * (k_ext - KK_W'(1));  // k=0 gives 0
  assign tri_w     = DATA_W'(kk >> 1);
  assign k_w       = DATA_W'(k_i);
  assign lin_term  = di_i * k_w;
  assign quad_term = ddi_i * tri_w;

  always_comb begin
    unique case (op_i)
      OP_LIN:  val_o = i_i + lin_term;
      OP_QUAD: val_o = i_i + lin_term + quad_term;
      default: val_o = i_i;
    endcase
  end
endmodule

// File: rtl/dfa_cell.sv
module dfa_cell
  import dfa_pkg::*;
#(
  parameter int unsigned DATA_W  = 36,
  parameter int unsigned COORD_W = 8,
  parameter int unsigned PIX_IDX = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               clear_i,
  input  dfa_op_e            op_i,
  input  logic               clip_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] dx_i,
  input  logic [DATA_W-1:0]  i_i,
  input  logic [DATA_W-1:0]  di_i,
  input  logic [DATA_W-1:0]  ddi_i,
  output logic [DATA_W-1:0]  acc_o,
  output logic               lock_o,
  output logic               mask_o
);
  localparam logic [COORD_W:0] IDX = (COORD_W+1)'(PIX_IDX);

  logic [COORD_W:0]   span_end;
  logic               in_span;
  logic [COORD_W-1:0] k;
  logic [DATA_W-1:0]  val;
  logic               is_eval;
  logic               take;
  logic               neg_skip;
  logic [DATA_W-1:0]  acc_q;
  logic               lock_q;
  logic               mask_q;

  assign span_end = {1'b0, x_i} + {1'b0, dx_i};
  assign in_span  = (IDX >= {1'b0, x_i}) && (IDX < span_end);
  assign k        = COORD_W'(IDX - {1'b0, x_i});
  assign is_eval  = (op_i == OP_SET) || (op_i == OP_CONST) ||
                    (op_i == OP_LIN) || (op_i == OP_QUAD);
  assign take     = is_eval && in_span && !mask_q && !lock_q;
  assign neg_skip = clip_i && val[DATA_W-1];

  dfa_interp #(.DATA_W(DATA_W), .COORD_W(COORD_W)) u_interp (
    .k_i   (k),
    .op_i  (op_i),
    .i_i   (i_i),
    .di_i  (di_i),
    .ddi_i (ddi_i),
    .val_o (val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      lock_q <= 1'b0;
      mask_q <= 1'b0;
    end else if (clear_i) begin
      acc_q  <= '0;
      lock_q <= 1'b0;
      mask_q <= 1'b0;
    end else if (fire_i) begin
      if (op_i == OP_MASK && in_span) mask_q <= 1'b1;
      if (is_eval) mask_q <= 1'b0;
      if (take) begin
        if (op_i == OP_SET) begin
          acc_q  <= i_i;
          lock_q <= 1'b1;
        end else if (!neg_skip) begin
          acc_q <= acc_q + val;
        end
      end
    end
  end

  assign acc_o  = acc_q;
  assign lock_o = lock_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/dfa_shift_out.sv
module dfa_shift_out #(
  parameter int unsigned NUM_PIX = 16,
  parameter int unsigned PIX_W   = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [NUM_PIX*PIX_W-1:0] vals_i,
  output logic [PIX_W-1:0]         pix_o,
  output logic                     pix_valid_o,
  output logic                     busy_o
);
  localparam int unsigned CNT_W = $clog2(NUM_PIX + 1);
  localparam int unsigned SH_W  = NUM_PIX * PIX_W;

  logic [SH_W-1:0]  shreg_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      shreg_q <= vals_i;
      cnt_q   <= CNT_W'(NUM_PIX);
    end else if (cnt_q != '0) begin
      shreg_q <= shreg_q >> PIX_W;
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  assign pix_o       = shreg_q[PIX_W-1:0];
  assign pix_valid_o = (cnt_q != '0);
  assign busy_o      = (cnt_q != '0);
endmodule

// File: rtl/dfa_scanline.sv
module dfa_scanline
  import dfa_pkg::*;
#(
  parameter int unsigned NUM_PIX = 16,
  parameter int unsigned DATA_W  = 36,
  parameter int unsigned COORD_W = 8,
  parameter int unsigned PIX_W   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  output logic               instr_ready_o,
  input  logic [2:0]         instr_op_i,
  input  logic               instr_clip_i,
  input  logic [COORD_W-1:0] instr_x_i,
  input  logic [COORD_W-1:0] instr_dx_i,
  input  logic [DATA_W-1:0]  instr_i_i,
  input  logic [DATA_W-1:0]  instr_di_i,
  input  logic [DATA_W-1:0]  instr_ddi_i,
  output logic               pix_valid_o,
  output logic [PIX_W-1:0]   pix_o
);
  localparam int unsigned FLAT_W = NUM_PIX * PIX_W;

  dfa_op_e                    op;
  logic                       accept;
  logic                       refresh_go;
  logic                       cell_fire;
  logic                       busy;
  logic [NUM_PIX-1:0]         lock_vec;
  logic [NUM_PIX-1:0]         mask_vec;
  logic [NUM_PIX*DATA_W-1:0]  acc_flat;
  logic [FLAT_W-1:0]          top_flat;

  assign op         = dfa_op_e'(instr_op_i);
  assign accept     = instr_valid_i && instr_ready_o;
  assign refresh_go = accept && (op == OP_REFRESH);
  assign cell_fire  = accept && (op != OP_REFRESH);

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_cell
    logic [DATA_W-1:0] acc;
    dfa_cell #(
      .DATA_W (DATA_W),
      .COORD_W(COORD_W),
      .PIX_IDX(p)
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .fire_i (cell_fire),
      .clear_i(refresh_go),
      .op_i   (op),
      .clip_i (instr_clip_i),
      .x_i    (instr_x_i),
      .dx_i   (instr_dx_i),
      .i_i    (instr_i_i),
      .di_i   (instr_di_i),
      .ddi_i  (instr_ddi_i),
      .acc_o  (acc),
      .lock_o (lock_vec[p]),
      .mask_o (mask_vec[p])
    );
    assign acc_flat[p*DATA_W +: DATA_W] = acc;
    assign top_flat[p*PIX_W +: PIX_W]   = acc[DATA_W-1 -: PIX_W];
  end

  dfa_shift_out #(.NUM_PIX(NUM_PIX), .PIX_W(PIX_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (refresh_go),
    .vals_i     (top_flat),
    .pix_o      (pix_o),
    .pix_valid_o(pix_valid_o),
    .busy_o     (busy)
  );

  assign instr_ready_o = !busy;
endmodule

// File: rtl/dfa_scanline_chk.sv
module dfa_scanline_chk #(
  parameter int unsigned NUM_PIX = 16,
  parameter int unsigned DATA_W  = 36
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      instr_valid_i,
  input logic                      instr_ready_o,
  input logic [2:0]                instr_op_i,
  input logic                      pix_valid_o,
  input logic [NUM_PIX-1:0]        lock_vec,
  input logic [NUM_PIX-1:0]        mask_vec,
  input logic [NUM_PIX*DATA_W-1:0] acc_flat
);
  localparam int unsigned RUN_W = $clog2(NUM_PIX + 2);

  logic accept, refresh_acc, eval_acc;
  logic [RUN_W-1:0] run_q;

  assign accept      = instr_valid_i && instr_ready_o;
  assign refresh_acc = accept && (instr_op_i == 3'd6);
  assign eval_acc    = accept && (instr_op_i >= 3'd1) && (instr_op_i <= 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (pix_valid_o) run_q <= run_q + RUN_W'(1);
    else run_q <= '0;
  end

  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> !instr_ready_o); // R9
  AST_REFRESH_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_acc |=> (pix_valid_o && !instr_ready_o)); // R9
  AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pix_valid_o) |-> (run_q == RUN_W'(NUM_PIX))); // R9
  AST_REFRESH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_acc |=> (lock_vec == '0 && mask_vec == '0)); // R9
  AST_MASK_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_acc |=> (mask_vec == '0)); // R7

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_lock
    AST_LOCK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_vec[p] && !refresh_acc) |=>
        (lock_vec[p] && $stable(acc_flat[p*DATA_W +: DATA_W]))); // R6
  end
endmodule

bind dfa_scanline dfa_scanline_chk #(.NUM_PIX(NUM_PIX), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_valid_i(instr_valid_i),
  .instr_ready_o(instr_ready_o),
  .instr_op_i   (instr_op_i),
  .pix_valid_o  (pix_valid_o),
  .lock_vec     (lock_vec),
  .mask_vec     (mask_vec),
  .acc_flat     (acc_flat)
);

// File: tb/dfa_scanline_tb.sv
`timescale 1ns/1ps
module dfa_scanline_tb_top;
  localparam int N  = 16;
  localparam int DW = 36;
  localparam int CW = 8;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic          ready;
  logic [2:0]    op = '0;
  logic          clip = 1'b0;
  logic [CW-1:0] x = '0, dx = '0;
  logic [DW-1:0] iv = '0, div = '0, ddiv = '0;
  logic          pvalid;
  logic [PW-1:0] pix;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [DW-1:0] m_acc [N];
  bit            m_lock [N];
  bit            m_mask [N];

  always #2 clk = ~clk;

  dfa_scanline #(.NUM_PIX(N), .DATA_W(DW), .COORD_W(CW), .PIX_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(valid), .instr_ready_o(ready),
    .instr_op_i(op), .instr_clip_i(clip), .instr_x_i(x), .instr_dx_i(dx),
    .instr_i_i(iv), .instr_di_i(div), .instr_ddi_i(ddiv),
    .pix_valid_o(pvalid), .pix_o(pix)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int p = 0; p < N; p++) begin
      m_acc[p] = '0; m_lock[p] = 0; m_mask[p] = 0;
    end
  endtask

  task automatic model(int o, bit c, int xs, int ds,
                       logic [DW-1:0] a, logic [DW-1:0] d1, logic [DW-1:0] d2);
    logic [DW-1:0] v, s;
    if (o == 5)
      for (int p = xs; p < xs + ds; p++) if (p < N) m_mask[p] = 1;
    if (o >= 1 && o <= 4) begin
      v = a; s = d1;
      for (int p = xs; p < xs + ds; p++) begin
        if (p < N && !m_mask[p] && !m_lock[p]) begin
          if (o == 1) begin m_acc[p] = a; m_lock[p] = 1; end
          else if (!(c && v[DW-1])) m_acc[p] = m_acc[p] + v;
        end
        if (o == 3) v = v + d1;
        if (o == 4) begin v = v + s; s = s + d2; end
      end
      for (int p = 0; p < N; p++) m_mask[p] = 0;
    end
  endtask

  task automatic send(int o, bit c, int xs, int ds,
                      logic [DW-1:0] a, logic [DW-1:0] d1, logic [DW-1:0] d2);
    valid = 1; op = 3'(o); clip = c; x = CW'(xs); dx = CW'(ds);
    iv = a; div = d1; ddiv = d2;
    while (!ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    valid = 0;
    model(o, c, xs, ds, a, d1, d2);
  endtask

  task automatic refresh(string tag);
    send(6, 0, 0, 0, '0, '0, '0);
    for (int p = 0; p < N; p++) begin
      check(pvalid && !ready, "R9 shift handshake", {pvalid, ready}, 2'b10);
      check(pix == m_acc[p][DW-1 -: PW], tag, pix, m_acc[p][DW-1 -: PW]);
      @(negedge clk);
    end
    check(!pvalid && ready, "R9 shift end", {pvalid, ready}, 2'b01);
    model_clear();
  endtask

  function automatic logic [DW-1:0] rnd36();
    return DW'({$urandom(), $urandom()});
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    model_clear();
    repeat (3) @(negedge clk);
    check(ready && !pvalid, "R1 reset ports", {ready, pvalid}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    check(ready && !pvalid, "R1 idle after reset", {ready, pvalid}, 2'b10);
    refresh("R1 zero accumulators");

    send(2, 0, 3, 4, 36'h123_000000, '0, '0);
    refresh("R2 constant span");

    send(4, 0, 0, 16, '0, 36'h001_000000, 36'h001_000000);
    refresh("R4 quadratic span");
    send(4, 0, 5, 9, 36'hF00_000000, 36'hFFF_800000, 36'h000_300000);
    refresh("R4 quadratic wrap");

    send(2, 0, 2, 10, 36'h010_000000, '0, '0);
    send(3, 0, 4, 12, 36'h020_000000, 36'h003_000000, '0);
    refresh("R5 R3 overlap");

    send(1, 1, 6, 4, 36'h800_000000, '0, '0);
    send(2, 0, 0, 16, 36'h001_000000, '0, '0);
    send(1, 0, 6, 4, 36'h055_000000, '0, '0);
    refresh("R6 set and lock");

    send(5, 0, 4, 5, '0, '0, '0);
    send(2, 0, 0, 16, 36'h002_000000, '0, '0);
    send(2, 0, 0, 16, 36'h004_000000, '0, '0);
    refresh("R7 one-shot mask");

    send(3, 1, 0, 16, 36'h040_000000, 36'hFF8_000000, '0);
    send(3, 0, 0, 16, 36'h010_000000, 36'hFFE_000000, '0);
    refresh("R8 clip negatives");

    send(2, 0, 4, 0, 36'h111_000000, '0, '0);
    send(2, 0, 16, 5, 36'h222_000000, '0, '0);
    send(0, 0, 0, 16, 36'h333_000000, '0, '0);
    send(2, 0, 13, 40, 36'h001_000000, '0, '0);
    refresh("R10 empty spans R2 tail clip");

    for (int b = 0; b < 250; b++) begin
      for (int j = 0; j < 1 + int'($urandom_range(7)); j++)
        send(int'($urandom_range(5)), bit'($urandom_range(1)),
             int'($urandom_range(N + 3)), int'($urandom_range(N + 3)),
             rnd36(), rnd36(), rnd36());
      refresh("R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule